// File: doc/BRIEF.md
# Three-Phase PWM Generator with Per-Phase Output States

This block drives the six gate signals of a three-phase half-bridge stage. All three phases share one 12-bit counter. The counter runs against a programmable period in one of four modes: counting up, counting down, counting up then down, or holding its value. Each phase compares the counter with its own 12-bit duty value to form a raw PWM wave.

Each phase then passes the raw wave through a 3-bit output-state selector, which sets its high-side and low-side gate signals. The selector can turn both switches off, force one switch on, apply PWM to one switch only, or drive the two switches with complementary PWM. In complementary mode a programmable dead time delays each turn-on edge. A high-Z request from a neighbouring fault block turns every switch off. Period and duty values are double-buffered, so a new waveform starts only on a clean period boundary.

The external reset is asynchronous and active low. Its release is synchronized through two flops, so the core leaves reset on the second rising clock edge after release. Each gate output is registered and appears one clock after the counter value that produces it.

Top module: `tri_phase_pwm`

## Requirements
- R1: With cnt_mode = 1 (up), the counter steps 0, 1, …, P and then returns to 0, giving a PWM period of P+1 clocks, where P is the buffered period.
- R2: With cnt_mode = 2 (down), the counter steps P, P−1, …, 0 and then reloads P, giving a period of P+1 clocks.
- R3: With cnt_mode = 0 (up-down), the counter rises from 0 to P and then falls back to 0, giving a period of 2P clocks.
- R4: With cnt_mode = 3 (hold), the counter keeps its value and every phase output stays constant.
- R5: The raw PWM of a phase is high while the counter is below its duty D. D = 0 gives a wave that is always low. D ≥ P with D ≠ 0 gives a wave that is always high.
- R6: Period and duty inputs are copied into the working registers only on a period boundary or while the generator is disabled. A boundary is a wrap in up or down mode, or the counter leaving 0 while falling in up-down mode. At any other time, a change on those inputs has no effect on the outputs.
- R7: The 3-bit phase state selects the switch pair {high, low} as follows. 0 = both off. 1 = low side on. 2 = high side on. 5 = low side follows PWM, high side off. 6 = high side follows PWM, low side off. 7 = high side follows PWM and low side follows inverted PWM.
- R8: Phase-state codes 3 and 4 turn both switches of that phase off.
- R9: In state 7 only, dead-time code n (0 to 7) delays each rising edge of each switch by n·DT_STEP clocks while falling edges stay immediate. The two switches of a phase are never on together. A pulse shorter than the delay never appears.
- R10: While hiz_req is high, all six gate outputs are low from the next clock.
- R11: When gen_en is low, the counter returns to 0 and all six gate outputs are low from the next clock. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside before release |
| gen_en | input | 1 | Generator enable (1 = run) |
| cnt_mode | input | 2 | Counter mode: 0 up-down, 1 up, 2 down, 3 hold |
| period | input | 12 | Period value P (buffered) |
| duty_a | input | 12 | Duty of phase A (buffered) |
| duty_b | input | 12 | Duty of phase B (buffered) |
| duty_c | input | 12 | Duty of phase C (buffered) |
| state_a | input | 3 | Output-state code of phase A |
| state_b | input | 3 | Output-state code of phase B |
| state_c | input | 3 | Output-state code of phase C |
| dt_code | input | 3 | Dead-time code, in steps of DT_STEP clocks |
| hiz_req | input | 1 | High-Z request from the fault logic; forces all switches off |
| hs_a | output | 1 | Phase A high-side gate |
| ls_a | output | 1 | Phase A low-side gate |
| hs_b | output | 1 | Phase B high-side gate |
| ls_b | output | 1 | Phase B low-side gate |
| hs_c | output | 1 | Phase C high-side gate |
| ls_c | output | 1 | Phase C low-side gate |

## Verification
The bench builds the block with the default 12-bit counter and with DT_STEP set to 2 instead of 40. With that setting every dead-time code spans at most 14 clocks, and the periods used stay between 10 and 40 clocks. As a result, the suppressed short pulse (code 7 against a 10-clock pulse) and the partly trimmed pulse (code 2) both fall inside short measurement windows. The small periods also let every counter mode, the duty extremes and each phase-state code repeat over many full periods, while the behavioural model is compared on every clock.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

  localparam int NPH = 3;

  typedef enum logic [1:0] {
    CM_UPDN = 2'd0,
    CM_UP   = 2'd1,
    CM_DOWN = 2'd2,
    CM_HOLD = 2'd3
  } cmode_e;

  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_LS_ON  = 3'd1,
    PS_HS_ON  = 3'd2,
    PS_RSV3   = 3'd3,
    PS_RSV4   = 3'd4,
    PS_LS_PWM = 3'd5,
    PS_HS_PWM = 3'd6,
    PS_COMP   = 3'd7
  } pstate_e;

endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp
  import tri_pwm_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [1:0]            mode,
  input  logic [W-1:0]          period_in,
  input  logic [NPH-1:0][W-1:0] duty_in,
  output logic [W-1:0]          cnt_q,
  output logic [W-1:0]          prd_q,
  output logic [NPH-1:0][W-1:0] duty_q
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  cmode_e       mode_e;
  logic [W-1:0] cnt_d;
  logic         dn_q, dn_d;
  logic         ld;

  assign mode_e = cmode_e'(mode);

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    ld    = 1'b0;
    if (!en) begin
      cnt_d = '0;
      dn_d  = 1'b0;
      ld    = 1'b1;
    end else begin
      case (mode_e)
        CM_UP: begin
          if (cnt_q >= prd_q) begin
            cnt_d = '0;
            ld    = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        CM_DOWN: begin
          if (cnt_q == '0) begin
            cnt_d = period_in;
            ld    = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        CM_UPDN: begin
          if (!dn_q) begin
            if (cnt_q >= prd_q) begin
              dn_d  = 1'b1;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else if (cnt_q == '0) begin
            dn_d  = 1'b0;
            ld    = 1'b1;
            cnt_d = (period_in == '0) ? '0 : ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dn_q   <= 1'b0;
      prd_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
      if (ld) begin
        prd_q  <= period_in;
        duty_q <= duty_in;
      end
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= prd_q);

  // R6
  prd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CM_UP && $past(en) && $past(mode) == CM_UP && cnt_q != '0)
      |-> $stable(prd_q));

endmodule

// File: rtl/gate_stage.sv
module gate_stage
  import tri_pwm_pkg::*;
#(
  parameter int W       = 12,
  parameter int DT_STEP = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         hiz,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] prd,
  input  logic [W-1:0] duty,
  input  logic [2:0]   state,
  input  logic [2:0]   dt_code,
  output logic         hs_q,
  output logic         ls_q
);

  localparam int RUN_MAX = 7 * DT_STEP;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  pstate_e          st_e;
  logic             pwm;
  logic             want_h, want_l;
  logic [RUN_W-1:0] eff_dt;
  logic [RUN_W-1:0] run_h_q, run_h_d, run_l_q, run_l_d;
  logic             hs_d, ls_d;

  assign st_e   = pstate_e'(state);
  assign pwm    = (duty != '0) && ((duty >= prd) || (cnt < duty));
  assign eff_dt = (st_e == PS_COMP) ? RUN_W'(32'(dt_code) * DT_STEP) : '0;

  always_comb begin
    want_h = 1'b0;
    want_l = 1'b0;
    if (en && !hiz) begin
      case (st_e)
        PS_LS_ON:  want_l = 1'b1;
        PS_HS_ON:  want_h = 1'b1;
        PS_LS_PWM: want_l = pwm;
        PS_HS_PWM: want_h = pwm;
        PS_COMP: begin
          want_h = pwm;
          want_l = !pwm;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    run_h_d = !want_h ? '0 : ((run_h_q < eff_dt) ? run_h_q + 1'b1 : run_h_q);
    run_l_d = !want_l ? '0 : ((run_l_q < eff_dt) ? run_l_q + 1'b1 : run_l_q);
    hs_d    = want_h && (run_h_q >= eff_dt);
    ls_d    = want_l && (run_l_q >= eff_dt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_h_q <= '0;
      run_l_q <= '0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      run_h_q <= run_h_d;
      run_l_q <= run_l_d;
      hs_q    <= hs_d;
      ls_q    <= ls_d;
    end
  end

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  // R10
  hiz_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |=> (!hs_q && !ls_q));

  // R8
  rsv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 || state == 3'd4) |=> (!hs_q && !ls_q));

  // R11
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_q && !ls_q));

endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int DT_STEP = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [1:0]       cnt_mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_a,
  input  logic [CNT_W-1:0] duty_b,
  input  logic [CNT_W-1:0] duty_c,
  input  logic [2:0]       state_a,
  input  logic [2:0]       state_b,
  input  logic [2:0]       state_c,
  input  logic [2:0]       dt_code,
  input  logic             hiz_req,
  output logic             hs_a,
  output logic             ls_a,
  output logic             hs_b,
  output logic             ls_b,
  output logic             hs_c,
  output logic             ls_c
);

  logic [1:0]                rs_q;
  logic                      rst_core_n;
  logic [NPH-1:0][CNT_W-1:0] duty_in, duty_w;
  logic [NPH-1:0][2:0]       state_in;
  logic [CNT_W-1:0]          cnt_w, prd_w;
  logic [NPH-1:0]            hs_w, ls_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign duty_in  = {duty_c, duty_b, duty_a};
  assign state_in = {state_c, state_b, state_a};

  pwm_ramp #(.W(CNT_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en        (gen_en),
    .mode      (cnt_mode),
    .period_in (period),
    .duty_in   (duty_in),
    .cnt_q     (cnt_w),
    .prd_q     (prd_w),
    .duty_q    (duty_w)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    gate_stage #(.W(CNT_W), .DT_STEP(DT_STEP)) u_gate (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .en      (gen_en),
      .hiz     (hiz_req),
      .cnt     (cnt_w),
      .prd     (prd_w),
      .duty    (duty_w[p]),
      .state   (state_in[p]),
      .dt_code (dt_code),
      .hs_q    (hs_w[p]),
      .ls_q    (ls_w[p])
    );
  end

  assign hs_a = hs_w[0];
  assign ls_a = ls_w[0];
  assign hs_b = hs_w[1];
  assign ls_b = ls_w[1];
  assign hs_c = hs_w[2];
  assign ls_c = ls_w[2];

endmodule

// File: tb/test_tri_phase_pwm.sv
`timescale 1ns/1ps
module test_tri_phase_pwm;

  localparam int STEP = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        gen_en;
  logic [1:0]  cnt_mode;
  logic [11:0] period, duty_a, duty_b, duty_c;
  logic [2:0]  state_a, state_b, state_c, dt_code;
  logic        hiz_req;
  logic        hs_a, ls_a, hs_b, ls_b, hs_c, ls_c;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  tri_phase_pwm #(.CNT_W(12), .DT_STEP(STEP)) i_tri_phase_pwm (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .cnt_mode(cnt_mode),
    .period(period), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .state_a(state_a), .state_b(state_b), .state_c(state_c),
    .dt_code(dt_code), .hiz_req(hiz_req),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .hs_c(hs_c), .ls_c(ls_c)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_rs0, m_rs1, m_dn;
  int m_cnt, m_prd, nc, per, eff;
  bit nd, ld, pw, wh, wl;
  int m_duty[3];
  int m_rh[3];
  int m_rl[3];
  bit e_hs[3];
  bit e_ls[3];
  int din[3];
  int sin[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs0 = 0; m_rs1 = 0; m_dn = 0; m_cnt = 0; m_prd = 0;
      for (int p = 0; p < 3; p++) begin
        m_duty[p] = 0; m_rh[p] = 0; m_rl[p] = 0; e_hs[p] = 0; e_ls[p] = 0;
      end
    end else begin
      if (m_rs1) begin
        din[0] = int'(duty_a); din[1] = int'(duty_b); din[2] = int'(duty_c);
        sin[0] = int'(state_a); sin[1] = int'(state_b); sin[2] = int'(state_c);
        per = int'(period);
        for (int p = 0; p < 3; p++) begin
          pw = (m_duty[p] != 0) && ((m_duty[p] >= m_prd) || (m_cnt < m_duty[p]));
          wh = 0; wl = 0;
          if (gen_en && !hiz_req) begin
            case (sin[p])
              1: wl = 1;
              2: wh = 1;
              5: wl = pw;
              6: wh = pw;
              7: begin wh = pw; wl = !pw; end
              default: ;
            endcase
          end
          eff = (sin[p] == 7) ? int'(dt_code) * STEP : 0;
          e_hs[p] = wh && (m_rh[p] >= eff);
          e_ls[p] = wl && (m_rl[p] >= eff);
          m_rh[p] = !wh ? 0 : ((m_rh[p] < eff) ? m_rh[p] + 1 : m_rh[p]);
          m_rl[p] = !wl ? 0 : ((m_rl[p] < eff) ? m_rl[p] + 1 : m_rl[p]);
        end
        nc = m_cnt; nd = m_dn; ld = 0;
        if (!gen_en) begin
          nc = 0; nd = 0; ld = 1;
        end else begin
          case (cnt_mode)
            2'd1: if (m_cnt >= m_prd) begin nc = 0; ld = 1; end else nc = m_cnt + 1;
            2'd2: if (m_cnt == 0) begin nc = per; ld = 1; end else nc = m_cnt - 1;
            2'd0: begin
              if (!m_dn) begin
                if (m_cnt >= m_prd) begin nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else nc = m_cnt + 1;
              end else if (m_cnt == 0) begin
                nd = 0; ld = 1; nc = (per == 0) ? 0 : 1;
              end else nc = m_cnt - 1;
            end
            default: ;
          endcase
        end
        if (ld) begin
          m_prd = per;
          for (int p = 0; p < 3; p++) m_duty[p] = din[p];
        end
        m_cnt = nc; m_dn = nd;
      end
      m_rs1 = m_rs0; m_rs0 = 1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit ah[3];
      bit al[3];
      string tag;
      ah[0] = hs_a; ah[1] = hs_b; ah[2] = hs_c;
      al[0] = ls_a; al[1] = ls_b; al[2] = ls_c;
      for (int p = 0; p < 3; p++) begin
        if (hiz_req)                                   tag = "R10";
        else if (!gen_en)                              tag = "R11";
        else if (sin[p] == 7)                          tag = "R9";
        else if (sin[p] == 3 || sin[p] == 4)           tag = "R8";
        else                                           tag = "R7";
        chk(ah[p] == e_hs[p], {tag, " model hs"}, int'(ah[p]), int'(e_hs[p]));
        chk(al[p] == e_ls[p], {tag, " model ls"}, int'(al[p]), int'(e_ls[p]));
      end
    end
  end

  int c_hs[3];
  int c_ls[3];
  int ovl;

  task automatic measure(input int n);
    for (int p = 0; p < 3; p++) begin c_hs[p] = 0; c_ls[p] = 0; end
    ovl = 0;
    repeat (n) begin
      @(negedge clk);
      c_hs[0] += int'(hs_a); c_hs[1] += int'(hs_b); c_hs[2] += int'(hs_c);
      c_ls[0] += int'(ls_a); c_ls[1] += int'(ls_b); c_ls[2] += int'(ls_c);
      if ((hs_a && ls_a) || (hs_b && ls_b) || (hs_c && ls_c)) ovl++;
    end
  endtask

  task automatic settle();
    repeat (45) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; gen_en = 0; cnt_mode = 2'd1; period = 12'd9;
    duty_a = 12'd3; duty_b = 12'd0; duty_c = 12'd15;
    state_a = 3'd6; state_b = 3'd6; state_c = 3'd6;
    dt_code = 3'd0; hiz_req = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({hs_a, ls_a, hs_b, ls_b, hs_c, ls_c} == 6'b0, "R11 reset outputs",
        int'({hs_a, ls_a, hs_b, ls_b, hs_c, ls_c}), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    measure(5);
    chk(c_hs[0] + c_hs[2] == 0, "R11 disabled after reset", c_hs[0] + c_hs[2], 0);

    // R1 up mode, R5 duty extremes
    gen_en = 1;
    settle(); measure(20);
    chk(c_hs[0] == 6,  "R1 up mode duty 3 of 10", c_hs[0], 6);
    chk(c_hs[1] == 0,  "R5 duty zero", c_hs[1], 0);
    chk(c_hs[2] == 20, "R5 duty above period", c_hs[2], 20);
    chk(c_ls[0] == 0,  "R7 state 6 keeps low side off", c_ls[0], 0);

    // R2 down mode
    cnt_mode = 2'd2;
    settle(); measure(20);
    chk(c_hs[0] == 6, "R2 down mode duty 3 of 10", c_hs[0], 6);

    // R3 up-down mode
    cnt_mode = 2'd0;
    settle(); measure(36);
    chk(c_hs[0] == 10, "R3 up-down duty 3 of 18", c_hs[0], 10);

    // R4 hold mode
    cnt_mode = 2'd3;
    settle(); measure(20);
    chk(c_hs[0] == 0 || c_hs[0] == 20, "R4 hold keeps output static", c_hs[0], 20);

    // R6 duty change without a boundary has no effect
    begin
      int v;
      v = int'(hs_a);
      duty_a = (v != 0) ? 12'd0 : 12'd15;
      repeat (10) @(negedge clk);
      measure(10);
      chk(c_hs[0] == v * 10, "R6 buffered duty ignored in hold", c_hs[0], v * 10);
    end

    // R7 / R8 phase states
    cnt_mode = 2'd1; duty_a = 12'd3;
    state_a = 3'd0; settle(); measure(20);
    chk(c_hs[0] + c_ls[0] == 0, "R7 state 0 both off", c_hs[0] + c_ls[0], 0);
    state_a = 3'd1; settle(); measure(20);
    chk(c_ls[0] == 20 && c_hs[0] == 0, "R7 state 1 low on", c_ls[0], 20);
    state_a = 3'd2; settle(); measure(20);
    chk(c_hs[0] == 20 && c_ls[0] == 0, "R7 state 2 high on", c_hs[0], 20);
    state_a = 3'd5; settle(); measure(20);
    chk(c_ls[0] == 6 && c_hs[0] == 0, "R7 state 5 low pwm", c_ls[0], 6);
    state_a = 3'd3; settle(); measure(20);
    chk(c_hs[0] + c_ls[0] == 0, "R8 state 3 off", c_hs[0] + c_ls[0], 0);
    state_a = 3'd4; settle(); measure(20);
    chk(c_hs[0] + c_ls[0] == 0, "R8 state 4 off", c_hs[0] + c_ls[0], 0);

    // R9 dead time
    period = 12'd19; duty_a = 12'd10; state_a = 3'd7; dt_code = 3'd0;
    settle(); measure(40);
    chk(c_hs[0] == 20 && c_ls[0] == 20, "R9 complementary no delay", c_hs[0] + c_ls[0], 40);
    dt_code = 3'd2;
    settle(); measure(40);
    chk(c_hs[0] == 12, "R9 high side trimmed by 4", c_hs[0], 12);
    chk(c_ls[0] == 12, "R9 low side trimmed by 4", c_ls[0], 12);
    chk(ovl == 0, "R9 no overlap", ovl, 0);
    dt_code = 3'd7;
    settle(); measure(40);
    chk(c_hs[0] + c_ls[0] == 0, "R9 pulse shorter than delay dropped", c_hs[0] + c_ls[0], 0);
    state_a = 3'd6; dt_code = 3'd2;
    settle(); measure(40);
    chk(c_hs[0] == 20, "R9 delay only in state 7", c_hs[0], 20);

    // R10 high-Z override
    state_b = 3'd1; hiz_req = 1;
    repeat (2) @(negedge clk); measure(20);
    chk(c_hs[0] + c_hs[2] + c_ls[1] == 0, "R10 hiz forces off",
        c_hs[0] + c_hs[2] + c_ls[1], 0);
    hiz_req = 0;
    settle(); measure(20);
    chk(c_ls[1] == 20, "R10 release restores output", c_ls[1], 20);

    // R11 disable
    gen_en = 0;
    repeat (2) @(negedge clk); measure(10);
    chk(c_hs[0] + c_hs[2] + c_ls[1] == 0, "R11 disable forces off",
        c_hs[0] + c_hs[2] + c_ls[1], 0);

    finish_run();
  end

endmodule